// File: doc/BRIEF.md
# Prioritized Power-Mode Sequencer

This block chooses the power mode of a processor subsystem. Every clock it looks at a set of fault lines, on/off/MCU requests, two wake pins, two sleep signals and four software request bits. Among the triggers that are both active and allowed in the present mode, it takes the one with the lowest priority index. It then moves the mode register and names the power sequence that the regulator logic outside the block must run. The modes are STANDBY, ACTIVE, MCU_ONLY, SUSPEND_TO_RAM and SAFE.

Each accepted trigger raises a one-cycle start pulse and loads a sequence code. The outside logic answers with a done pulse when the ramp has finished. While a sequence is outstanding, only the three shutdown-class faults are accepted, and they pre-empt it. A power fault on the SoC rail moves the block to MCU_ONLY and locks out every path back towards ACTIVE or suspend until software has acknowledged the fault. Finishing a sequence in SAFE counts one recovery attempt. Once the count reaches a programmable limit, the block latches a halt. Enabling CRC holds a neighbouring interface off for a configurable number of cycles.

Top module: `pwr_mode_seq`

## Requirements
- R1: The reset input is asynchronous and active low. During reset and after it, the mode is STANDBY (code 0), seqStart and halted are low, seqCode is 0, ifDisable is low, the recovery count is cleared and the lockout is released. Mode codes: STANDBY 0, ACTIVE 1, MCU_ONLY 2, SUSPEND_TO_RAM 3, SAFE 4.
- R2: Among triggers that are active and allowed in the current mode, the one with the lowest index wins. All others are dropped in that cycle. The index order is: shutdownNow, mcuPwrErr, orderlyOff, offReq edge, wdogErr (ACTIVE), esmSocErr, wdogErr (MCU_ONLY), socPwrErr, software bit 1, software bit 2, onReq edge, wake1 edge, sleep pair to 11, mcuOnReq edge, wake2 edge, sleep pair to 01, sleep pair to 00, sleep pair to 10, software bit 0, software bit 3.
- R3: shutdownNow, mcuPwrErr and orderlyOff are accepted from any mode except SAFE. They enter SAFE with codes 1, 2 and 3 respectively.
- R4: wdogErr in ACTIVE starts code 5 and esmSocErr in ACTIVE starts code 6, both staying in ACTIVE. wdogErr in MCU_ONLY starts code 7 and stays in MCU_ONLY. These fault triggers are level-sensitive and are accepted again whenever the block is not busy.
- R5: socPwrErr in ACTIVE enters MCU_ONLY with code 8. It engages a lockout that blocks the onReq, wake1, sleep-to-11, sleep-to-00 and sleep-to-10 triggers.
- R6: The lockout releases only after two things have happened, in either order: a sleep-to-01 trigger has been accepted, and irqClear has been pulsed. Until both have occurred, the blocked triggers start nothing.
- R7: Each effective sleep signal is its pin OR its register bit. A change of the effective pair {sleep1, sleep2} fires one trigger, chosen by the new value. 11 goes to ACTIVE (code 11). 01 goes to MCU_ONLY (code 12) from ACTIVE, MCU_ONLY or SUSPEND_TO_RAM. 00 or 10 goes to SUSPEND_TO_RAM (code 13), but only from ACTIVE or MCU_ONLY.
- R8: A pulse on swReqSet[n] makes software bit n pending. The bit stays pending until it wins, and winning clears it. Bit 0 enters STANDBY with code 4 from STANDBY, ACTIVE or MCU_ONLY. Bits 1, 2 and 3 are allowed in ACTIVE or MCU_ONLY, leave the mode unchanged and start codes 9, 10 and 14.
- R9: seqStart is a one-cycle pulse per accepted trigger. From an accept until seqDone, only shutdownNow, mcuPwrErr and orderlyOff can start a sequence.
- R10: seqDone while busy in SAFE adds one to the recovery count. If the new count is below recovThresh, the block returns to STANDBY. Otherwise it stays in SAFE with halted high and accepts nothing until reset.
- R11: Starting code 10 drives ifDisable high for exactly CRC_HOLD cycles.
- R12: onReq, mcuOnReq, offReq, wake1 and wake2 act on a rising edge seen against the previous cycle. onReq and wake1 go to ACTIVE (code 11), mcuOnReq and wake2 go to MCU_ONLY (code 12), and offReq goes to STANDBY (code 4). Each is allowed from any mode except SAFE.
- R13: All decisions are registered. Inputs present before a rising clock edge are reflected in pwrState, seqCode and seqStart right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shutdownNow | input | 1 | Immediate shutdown fault |
| mcuPwrErr | input | 1 | MCU rail power fault |
| orderlyOff | input | 1 | Orderly shutdown request |
| offReq | input | 1 | Off request (edge) |
| onReq | input | 1 | On request (edge) |
| mcuOnReq | input | 1 | MCU-only request (edge) |
| wdogErr | input | 1 | Watchdog error |
| esmSocErr | input | 1 | SoC error-signal fault |
| socPwrErr | input | 1 | SoC rail power fault |
| irqClear | input | 1 | Software acknowledge of SoC power fault |
| wake1 | input | 1 | Wake pin to ACTIVE (edge) |
| wake2 | input | 1 | Wake pin to MCU_ONLY (edge) |
| sleep1Pin | input | 1 | Sleep signal 1, pin |
| sleep2Pin | input | 1 | Sleep signal 2, pin |
| sleep1Reg | input | 1 | Sleep signal 1, register override |
| sleep2Reg | input | 1 | Sleep signal 2, register override |
| swReqSet | input | 4 | Set pulses for the self-clearing software bits |
| seqDone | input | 1 | Sequence completed |
| recovThresh | input | RCNT_W | Recovery attempt limit |
| pwrState | output | 3 | Current mode code |
| seqCode | output | 4 | Code of the last started sequence |
| seqStart | output | 1 | One-cycle sequence start |
| halted | output | 1 | Recovery given up, latched |
| ifDisable | output | 1 | Neighbour interface held off after CRC enable |

## Verification
The bench builds the block with CRC_HOLD = 6 and RCNT_W = 3 and drives recovThresh to 3. The short hold makes it possible to count the full ifDisable window cycle by cycle. The threshold of 3 lets two SAFE entries fall back to STANDBY and a third latch the halt within one short run. At the default two-millisecond hold, neither would fit.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PS_STANDBY = 3'd0,
    PS_ACTIVE  = 3'd1,
    PS_MCU     = 3'd2,
    PS_S2R     = 3'd3,
    PS_SAFE    = 3'd4
  } pstate_e;

  typedef enum logic [3:0] {
    SQ_NONE         = 4'd0,
    SQ_SAFE_SEVERE  = 4'd1,
    SQ_SAFE         = 4'd2,
    SQ_SAFE_ORDERLY = 4'd3,
    SQ_TO_STANDBY   = 4'd4,
    SQ_WARM_ACTIVE  = 4'd5,
    SQ_ESM_SOC      = 4'd6,
    SQ_WARM_MCU     = 4'd7,
    SQ_PWR_SOC      = 4'd8,
    SQ_BIST         = 4'd9,
    SQ_CRC_ON       = 4'd10,
    SQ_TO_ACTIVE    = 4'd11,
    SQ_TO_MCU       = 4'd12,
    SQ_TO_S2R       = 4'd13,
    SQ_UPD_PREP     = 4'd14
  } seq_e;

  localparam int NUM_TRIG  = 20;
  localparam int TRIG_W    = $clog2(NUM_TRIG);
  localparam int PREEMPT_N = 3;   // indices below this pre-empt a running sequence
  localparam int ID_SOCPWR = 7;
  localparam int ID_SLP01  = 15;

  // control -> datapath strobes
  typedef struct packed {
    logic [3:0] swConsume;
    logic       crcLoad;
    logic       recovInc;
  } dp_strobe_t;

  typedef struct packed {
    pstate_e target;
    logic    keep;
    seq_e    seq;
  } trig_act_t;

  function automatic trig_act_t trigAction(input int id);
    trig_act_t a;
    a = '{target: PS_STANDBY, keep: 1'b1, seq: SQ_NONE};
    case (id)
      0:           a = '{PS_SAFE, 1'b0, SQ_SAFE_SEVERE};
      1:           a = '{PS_SAFE, 1'b0, SQ_SAFE};
      2:           a = '{PS_SAFE, 1'b0, SQ_SAFE_ORDERLY};
      3, 18:       a = '{PS_STANDBY, 1'b0, SQ_TO_STANDBY};
      4:           a = '{PS_ACTIVE, 1'b1, SQ_WARM_ACTIVE};
      5:           a = '{PS_ACTIVE, 1'b1, SQ_ESM_SOC};
      6:           a = '{PS_MCU, 1'b1, SQ_WARM_MCU};
      7:           a = '{PS_MCU, 1'b0, SQ_PWR_SOC};
      8:           a = '{PS_STANDBY, 1'b1, SQ_BIST};
      9:           a = '{PS_STANDBY, 1'b1, SQ_CRC_ON};
      10, 11, 12:  a = '{PS_ACTIVE, 1'b0, SQ_TO_ACTIVE};
      13, 14, 15:  a = '{PS_MCU, 1'b0, SQ_TO_MCU};
      16, 17:      a = '{PS_S2R, 1'b0, SQ_TO_S2R};
      19:          a = '{PS_STANDBY, 1'b1, SQ_UPD_PREP};
      default:     a = '{PS_STANDBY, 1'b1, SQ_NONE};
    endcase
    return a;
  endfunction

  function automatic logic trigAllowed(input int id, input pstate_e st, input logic masked);
    logic run, act, mcu;
    run = (st != PS_SAFE);
    act = (st == PS_ACTIVE);
    mcu = (st == PS_MCU);
    case (id)
      0, 1, 2, 3:  return run;
      4, 5, 7:     return act;
      6:           return mcu;
      8, 9, 19:    return act | mcu;
      10, 11, 12:  return run & ~masked;
      13, 14:      return run;
      15:          return act | mcu | (st == PS_S2R);
      16, 17:      return (act | mcu) & ~masked;
      18:          return act | mcu | (st == PS_STANDBY);
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pwr_seq_arb.sv
module pwr_seq_arb
  import pwr_seq_pkg::*;
(
  input  logic [NUM_TRIG-1:0] trigRaw,
  input  pstate_e             curState,
  input  logic                wakeMask,
  input  logic                busy,
  output logic                winValid,
  output logic [TRIG_W-1:0]   winId
);

  logic [NUM_TRIG-1:0] elig;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : gElig
    assign elig[g] = trigRaw[g] && trigAllowed(g, curState, wakeMask)
                     && (!busy || (g < PREEMPT_N));
  end

  always_comb begin
    winValid = 1'b0;
    winId    = '0;
    for (int i = NUM_TRIG - 1; i >= 0; i--) begin
      if (elig[i]) begin
        winValid = 1'b1;
        winId    = TRIG_W'(i);
      end
    end
  end

endmodule

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int CRC_HOLD = 200000,
  parameter int RCNT_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                shutdownNow,
  input  logic                mcuPwrErr,
  input  logic                orderlyOff,
  input  logic                offReq,
  input  logic                onReq,
  input  logic                mcuOnReq,
  input  logic                wdogErr,
  input  logic                esmSocErr,
  input  logic                socPwrErr,
  input  logic                wake1,
  input  logic                wake2,
  input  logic                sleep1Pin,
  input  logic                sleep2Pin,
  input  logic                sleep1Reg,
  input  logic                sleep2Reg,
  input  logic [3:0]          swReqSet,
  input  logic [RCNT_W-1:0]   recovThresh,
  input  dp_strobe_t          strobe,
  output logic [NUM_TRIG-1:0] trigRaw,
  output logic                recovLimit,
  output logic                ifDisable
);

  localparam int CRC_W = $clog2(CRC_HOLD + 1);

  logic [1:0]        slpEff, slpQ;
  logic              offQ, onQ, mcuOnQ, wake1Q, wake2Q;
  logic [3:0]        swPend, swLive;
  logic [CRC_W-1:0]  crcCnt;
  logic [RCNT_W-1:0] recovCnt;
  logic [RCNT_W:0]   recovNext;
  logic              slpChg;

  assign slpEff = {sleep1Pin | sleep1Reg, sleep2Pin | sleep2Reg};
  assign slpChg = (slpEff != slpQ);
  assign swLive = swPend | swReqSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slpQ   <= 2'b00;
      offQ   <= 1'b0;
      onQ    <= 1'b0;
      mcuOnQ <= 1'b0;
      wake1Q <= 1'b0;
      wake2Q <= 1'b0;
      swPend <= 4'b0000;
    end else begin
      slpQ   <= slpEff;
      offQ   <= offReq;
      onQ    <= onReq;
      mcuOnQ <= mcuOnReq;
      wake1Q <= wake1;
      wake2Q <= wake2;
      swPend <= swLive & ~strobe.swConsume;
    end
  end

  always_comb begin
    trigRaw     = '0;
    trigRaw[0]  = shutdownNow;
    trigRaw[1]  = mcuPwrErr;
    trigRaw[2]  = orderlyOff;
    trigRaw[3]  = offReq & ~offQ;
    trigRaw[4]  = wdogErr;
    trigRaw[5]  = esmSocErr;
    trigRaw[6]  = wdogErr;
    trigRaw[7]  = socPwrErr;
    trigRaw[8]  = swLive[1];
    trigRaw[9]  = swLive[2];
    trigRaw[10] = onReq & ~onQ;
    trigRaw[11] = wake1 & ~wake1Q;
    trigRaw[12] = slpChg && (slpEff == 2'b11);
    trigRaw[13] = mcuOnReq & ~mcuOnQ;
    trigRaw[14] = wake2 & ~wake2Q;
    trigRaw[15] = slpChg && (slpEff == 2'b01);
    trigRaw[16] = slpChg && (slpEff == 2'b00);
    trigRaw[17] = slpChg && (slpEff == 2'b10);
    trigRaw[18] = swLive[0];
    trigRaw[19] = swLive[3];
  end

  // interface hold-off timer after CRC enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               crcCnt <= '0;
    else if (strobe.crcLoad) crcCnt <= CRC_W'(CRC_HOLD);
    else if (crcCnt != '0)   crcCnt <= crcCnt - 1'b1;
  end
  assign ifDisable = (crcCnt != '0);

  // recovery attempt counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                recovCnt <= '0;
    else if (strobe.recovInc) recovCnt <= recovNext[RCNT_W-1:0];
  end
  assign recovNext  = {1'b0, recovCnt} + (RCNT_W + 1)'(1);
  assign recovLimit = (recovNext >= {1'b0, recovThresh});

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              winValid,
  input  logic [TRIG_W-1:0] winId,
  input  logic              seqDone,
  input  logic              irqClear,
  input  logic              recovLimit,
  output pstate_e           curState,
  output seq_e              seqCode,
  output logic              seqStart,
  output logic              halted,
  output logic              busy,
  output logic              wakeMask,
  output dp_strobe_t        strobe
);

  trig_act_t act;
  logic      faultSeen, mcuAck, irqPend;
  logic      finish;

  assign act      = trigAction(int'(winId));
  assign wakeMask = faultSeen & ~(mcuAck & ~irqPend);
  assign finish   = !winValid && busy && seqDone;

  always_comb begin
    strobe = '0;
    if (winValid) begin
      case (int'(winId))
        8:  strobe.swConsume[1] = 1'b1;
        9:  begin
              strobe.swConsume[2] = 1'b1;
              strobe.crcLoad      = 1'b1;
            end
        18: strobe.swConsume[0] = 1'b1;
        19: strobe.swConsume[3] = 1'b1;
        default: ;
      endcase
    end
    strobe.recovInc = finish && (curState == PS_SAFE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= PS_STANDBY;
      seqCode  <= SQ_NONE;
      seqStart <= 1'b0;
      halted   <= 1'b0;
      busy     <= 1'b0;
    end else begin
      seqStart <= 1'b0;
      if (winValid) begin
        curState <= act.keep ? curState : act.target;
        seqCode  <= act.seq;
        seqStart <= 1'b1;
        busy     <= 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
        if (curState == PS_SAFE) begin
          if (recovLimit) halted   <= 1'b1;
          else            curState <= PS_STANDBY;
        end
      end
    end
  end

  // lockout after a SoC rail fault
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultSeen <= 1'b0;
      mcuAck    <= 1'b0;
      irqPend   <= 1'b0;
    end else if (winValid && (int'(winId) == ID_SOCPWR)) begin
      faultSeen <= 1'b1;
      mcuAck    <= 1'b0;
      irqPend   <= 1'b1;
    end else begin
      if (irqClear) irqPend <= 1'b0;
      if (winValid && (int'(winId) == ID_SLP01) && faultSeen) mcuAck <= 1'b1;
      if (faultSeen && mcuAck && !irqPend) begin
        faultSeen <= 1'b0;
        mcuAck    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int CRC_HOLD = 200000,
  parameter int RCNT_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shutdownNow,
  input  logic              mcuPwrErr,
  input  logic              orderlyOff,
  input  logic              offReq,
  input  logic              onReq,
  input  logic              mcuOnReq,
  input  logic              wdogErr,
  input  logic              esmSocErr,
  input  logic              socPwrErr,
  input  logic              irqClear,
  input  logic              wake1,
  input  logic              wake2,
  input  logic              sleep1Pin,
  input  logic              sleep2Pin,
  input  logic              sleep1Reg,
  input  logic              sleep2Reg,
  input  logic [3:0]        swReqSet,
  input  logic              seqDone,
  input  logic [RCNT_W-1:0] recovThresh,
  output logic [2:0]        pwrState,
  output logic [3:0]        seqCode,
  output logic              seqStart,
  output logic              halted,
  output logic              ifDisable
);

  logic [NUM_TRIG-1:0] trigRaw;
  logic                recovLimit, winValid, busy, wakeMask;
  logic [TRIG_W-1:0]   winId;
  dp_strobe_t          strobe;
  pstate_e             curState;
  seq_e                seqCodeE;

  pwr_seq_dp #(.CRC_HOLD(CRC_HOLD), .RCNT_W(RCNT_W)) i_dp (
    .clk(clk), .rstN(rstN),
    .shutdownNow(shutdownNow), .mcuPwrErr(mcuPwrErr), .orderlyOff(orderlyOff),
    .offReq(offReq), .onReq(onReq), .mcuOnReq(mcuOnReq),
    .wdogErr(wdogErr), .esmSocErr(esmSocErr), .socPwrErr(socPwrErr),
    .wake1(wake1), .wake2(wake2),
    .sleep1Pin(sleep1Pin), .sleep2Pin(sleep2Pin),
    .sleep1Reg(sleep1Reg), .sleep2Reg(sleep2Reg),
    .swReqSet(swReqSet), .recovThresh(recovThresh), .strobe(strobe),
    .trigRaw(trigRaw), .recovLimit(recovLimit), .ifDisable(ifDisable)
  );

  pwr_seq_arb i_arb (
    .trigRaw(trigRaw), .curState(curState), .wakeMask(wakeMask), .busy(busy),
    .winValid(winValid), .winId(winId)
  );

  pwr_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .winValid(winValid), .winId(winId),
    .seqDone(seqDone), .irqClear(irqClear), .recovLimit(recovLimit),
    .curState(curState), .seqCode(seqCodeE), .seqStart(seqStart),
    .halted(halted), .busy(busy), .wakeMask(wakeMask), .strobe(strobe)
  );

  assign pwrState = curState;
  assign seqCode  = seqCodeE;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] pwrState,
  input logic [3:0] seqCode,
  input logic       seqStart,
  input logic       halted,
  input logic       ifDisable
);

  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqStart && seqCode > 4'd3) |=> (!seqStart || (seqCode <= 4'd3)));

  // R3
  safe_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqStart && seqCode >= 4'd1 && seqCode <= 4'd3) |-> (pwrState == 3'd4));

  // R4
  warm_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqStart && (seqCode == 4'd5 || seqCode == 4'd6)) |-> (pwrState == 3'd1));

  // R5
  soc_fault_mcu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqStart && seqCode == 4'd8) |-> (pwrState == 3'd2));

  // R10
  halt_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && pwrState == 3'd4));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !seqStart);

  // R11
  crc_hold_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ifDisable) |-> (seqStart && seqCode == 4'd10));

endmodule

bind pwr_mode_seq pwr_seq_chk i_chk (
  .clk(clk), .rstN(rstN), .pwrState(pwrState), .seqCode(seqCode),
  .seqStart(seqStart), .halted(halted), .ifDisable(ifDisable)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;

  localparam int CRC_HOLD = 6;
  localparam int RCNT_W   = 3;

  localparam logic [15:0] M_SHUT = 16'h0001, M_MPE = 16'h0002, M_ORD = 16'h0004,
                          M_OFF = 16'h0008, M_ON = 16'h0010, M_MCUON = 16'h0020,
                          M_WDOG = 16'h0040, M_ESM = 16'h0080, M_SOCPE = 16'h0100,
                          M_IRQ = 16'h0200, M_W1 = 16'h0400, M_W2 = 16'h0800,
                          M_S1 = 16'h1000, M_S2 = 16'h2000, M_R1 = 16'h4000,
                          M_R2 = 16'h8000, M_NONE = 16'h0000;
  localparam logic [15:0] P = M_R1 | M_S2;   // effective sleep pair 11
  localparam logic [2:0] STB = 3'd0, ACT = 3'd1, MCU = 3'd2, S2R = 3'd3, SAFE = 3'd4;
  localparam logic [3:0] SW0 = 4'd0;

  typedef struct packed {
    logic [15:0] in;
    logic [3:0]  sw;
    logic        done;
    logic [2:0]  st;
    logic [3:0]  code;
    logic        start;
    logic [7:0]  tag;
  } vec_t;

  localparam int NVEC = 51;
  localparam vec_t VEC [NVEC] = '{
    '{M_NONE,       SW0, 1'b0, STB,  4'd0,  1'b0, 8'd13}, // R13 idle
    '{M_ON,         SW0, 1'b0, ACT,  4'd11, 1'b1, 8'd12}, // R12
    '{M_NONE,       SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd9},  // R9
    '{M_WDOG,       SW0, 1'b0, ACT,  4'd5,  1'b1, 8'd4},  // R4
    '{M_ESM,        SW0, 1'b0, ACT,  4'd0,  1'b0, 8'd9},  // R9 busy
    '{M_NONE,       SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd9},
    '{M_WDOG|M_ESM, SW0, 1'b0, ACT,  4'd5,  1'b1, 8'd2},  // R2
    '{M_NONE,       SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd9},
    '{M_ESM,        SW0, 1'b0, ACT,  4'd6,  1'b1, 8'd4},  // R4
    '{M_NONE,       SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd9},
    '{M_SOCPE,      SW0, 1'b0, MCU,  4'd8,  1'b1, 8'd5},  // R5
    '{M_NONE,       SW0, 1'b1, MCU,  4'd0,  1'b0, 8'd5},
    '{M_W1,         SW0, 1'b0, MCU,  4'd0,  1'b0, 8'd5},  // R5 masked wake
    '{M_S1|M_S2,    SW0, 1'b0, MCU,  4'd0,  1'b0, 8'd5},  // R5 masked sleep 11
    '{M_S2,         SW0, 1'b0, MCU,  4'd12, 1'b1, 8'd6},  // R6 ack
    '{M_S2,         SW0, 1'b1, MCU,  4'd0,  1'b0, 8'd6},
    '{M_S2|M_ON,    SW0, 1'b0, MCU,  4'd0,  1'b0, 8'd6},  // R6 still masked
    '{M_S2|M_IRQ,   SW0, 1'b0, MCU,  4'd0,  1'b0, 8'd6},
    '{M_S2|M_ON,    SW0, 1'b0, ACT,  4'd11, 1'b1, 8'd6},  // R6 released
    '{M_S2,         SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd6},
    '{M_S2|M_R1,    SW0, 1'b0, ACT,  4'd11, 1'b1, 8'd7},  // R7 reg override
    '{M_S2|M_R1,    SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd7},
    '{M_NONE,       SW0, 1'b0, S2R,  4'd13, 1'b1, 8'd7},  // R7 00
    '{M_NONE,       SW0, 1'b1, S2R,  4'd0,  1'b0, 8'd7},
    '{M_R1,         SW0, 1'b0, S2R,  4'd0,  1'b0, 8'd7},  // R7 10 invalid in S2R
    '{P,            SW0, 1'b0, ACT,  4'd11, 1'b1, 8'd7},
    '{P,            SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd7},
    '{P,          4'b1010, 1'b0, ACT, 4'd9, 1'b1, 8'd8},  // R8 bit1 beats bit3
    '{P,            SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd8},
    '{P,            SW0, 1'b0, ACT,  4'd14, 1'b1, 8'd8},  // R8 bit3 kept pending
    '{P,            SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd8},
    '{P,          4'b0001, 1'b0, STB, 4'd4, 1'b1, 8'd8},  // R8 bit0
    '{P,            SW0, 1'b1, STB,  4'd0,  1'b0, 8'd8},
    '{P,          4'b0100, 1'b0, STB, 4'd0, 1'b0, 8'd8},  // R8 bit2 not allowed here
    '{P|M_ON,       SW0, 1'b0, ACT,  4'd11, 1'b1, 8'd12},
    '{P,            SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd8},
    '{P,            SW0, 1'b0, ACT,  4'd10, 1'b1, 8'd8},  // R8 pending bit2
    '{P,            SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd11},
    '{P|M_W2,       SW0, 1'b0, MCU,  4'd12, 1'b1, 8'd12}, // R12 wake2
    '{P,            SW0, 1'b1, MCU,  4'd0,  1'b0, 8'd12},
    '{P|M_W1,       SW0, 1'b0, ACT,  4'd11, 1'b1, 8'd12}, // R12 wake1
    '{P,            SW0, 1'b1, ACT,  4'd0,  1'b0, 8'd12},
    '{P|M_MCUON,    SW0, 1'b0, MCU,  4'd12, 1'b1, 8'd12}, // R12 mcuOn
    '{P|M_SHUT,     SW0, 1'b0, SAFE, 4'd1,  1'b1, 8'd9},  // R9 pre-empt
    '{P,            SW0, 1'b1, STB,  4'd0,  1'b0, 8'd10}, // R10 count 1
    '{P|M_ORD|M_OFF, SW0, 1'b0, SAFE, 4'd3, 1'b1, 8'd2},  // R2 orderly over off
    '{P|M_OFF,      SW0, 1'b1, STB,  4'd0,  1'b0, 8'd10}, // R10 count 2
    '{P|M_MPE,      SW0, 1'b0, SAFE, 4'd2,  1'b1, 8'd3},  // R3
    '{P,            SW0, 1'b1, SAFE, 4'd0,  1'b0, 8'd10}, // R10 limit
    '{P|M_ON,       SW0, 1'b0, SAFE, 4'd0,  1'b0, 8'd10},
    '{P|M_SHUT,     SW0, 1'b0, SAFE, 4'd0,  1'b0, 8'd10}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] inBus = '0;
  logic [3:0] swReqSet = '0;
  logic seqDone = 1'b0;
  logic [2:0] pwrState;
  logic [3:0] seqCode;
  logic seqStart, halted, ifDisable;
  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.CRC_HOLD(CRC_HOLD), .RCNT_W(RCNT_W)) i_pwr_mode_seq (
    .clk(clk), .rstN(rstN),
    .shutdownNow(inBus[0]), .mcuPwrErr(inBus[1]), .orderlyOff(inBus[2]),
    .offReq(inBus[3]), .onReq(inBus[4]), .mcuOnReq(inBus[5]),
    .wdogErr(inBus[6]), .esmSocErr(inBus[7]), .socPwrErr(inBus[8]),
    .irqClear(inBus[9]), .wake1(inBus[10]), .wake2(inBus[11]),
    .sleep1Pin(inBus[12]), .sleep2Pin(inBus[13]),
    .sleep1Reg(inBus[14]), .sleep2Reg(inBus[15]),
    .swReqSet(swReqSet), .seqDone(seqDone), .recovThresh(3'd3),
    .pwrState(pwrState), .seqCode(seqCode), .seqStart(seqStart),
    .halted(halted), .ifDisable(ifDisable)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(pwrState == STB && !seqStart && !halted && seqCode == 4'd0 && !ifDisable, "R1",
        {pwrState, seqCode, seqStart, halted, ifDisable}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(pwrState == STB && !seqStart && !halted, "R1", {pwrState, seqStart, halted}, 0);

    for (int k = 0; k < NVEC; k++) begin
      inBus    = VEC[k].in;
      swReqSet = VEC[k].sw;
      seqDone  = VEC[k].done;
      @(negedge clk);
      chk(pwrState == VEC[k].st && seqStart == VEC[k].start &&
          (!VEC[k].start || seqCode == VEC[k].code),
          $sformatf("R%0d step %0d", VEC[k].tag, k),
          {pwrState, seqCode, seqStart}, {VEC[k].st, VEC[k].code, VEC[k].start});
    end
    inBus = '0; swReqSet = '0; seqDone = 1'b0;
    @(negedge clk);
    // R10 halt latched
    chk(halted && pwrState == SAFE, "R10", {halted, pwrState}, {1'b1, SAFE});

    // R1 asynchronous reset mid-cycle
    #2 rstN = 1'b0;
    #1 chk(pwrState == STB && !halted && !seqStart && !ifDisable, "R1",
           {pwrState, halted}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 hold window, entered through the sleep pair (R7)
    inBus = P;
    @(negedge clk);
    chk(pwrState == ACT && seqStart && seqCode == 4'd11, "R7",
        {pwrState, seqCode}, {ACT, 4'd11});
    seqDone = 1'b1;
    @(negedge clk);
    seqDone = 1'b0;
    swReqSet = 4'b0100;
    @(negedge clk);
    swReqSet = '0;
    chk(seqStart && seqCode == 4'd10 && ifDisable, "R11",
        {seqStart, seqCode, ifDisable}, {1'b1, 4'd10, 1'b1});
    n = 1;
    seqDone = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      seqDone = 1'b0;
      if (ifDisable) n++;
    end
    chk(n == CRC_HOLD, "R11", n, CRC_HOLD);
    chk(pwrState == ACT && !seqStart, "R11", pwrState, ACT);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule